// File: doc/BRIEF.md
# Boot-Time Host Transport Selector

This block runs once after every reset and decides which host link a controller will use: a serial peripheral interface, a four-wire UART with hardware flow control, or a two-wire UART. It looks at three sources in a fixed order. The first is a strap pin. The second is a stored configuration record, delivered over a small request/ready bundle. The third is the UART clear-to-send line, which the block watches for a host that holds it asserted. When a source settles the choice, the block raises a done flag and a one-hot select. Both stay fixed until the next reset.

Both asynchronous pins pass through a synchronizer before the block uses them. The strap is examined first. Next the block asks for the stored record and waits a bounded number of cycles for ready. If no usable record arrives, it polls clear-to-send. A clear-to-send level is accepted only after it has stayed low for a configurable number of consecutive cycles. Polling never gives up, so the block can wait indefinitely for a host to appear.

Top module: `hostsel_top`

## Requirements
- R1: While reset is active, and afterwards until detection completes, `sel_o` is 3'b000 and `done_o` is 0.
- R2: If the synchronized strap reads 0, the serial peripheral interface is selected (`sel_o` = 3'b001). The configuration request is never raised, and the stored record and clear-to-send are both ignored.
- R3: With the strap at 1, a ready response that carries valid=1, entry-present=1 and a code in `cfg_xport_i` selects the transport from the code: 2'b00 gives four-wire UART (3'b010), 2'b01 gives two-wire UART (3'b100), and 2'b10 gives serial peripheral interface (3'b001).
- R4: A ready response with valid=0, with entry-present=0, or with code 2'b11 selects nothing, and detection moves on to clear-to-send polling.
- R5: If ready has not arrived after CFG_TIMEOUT (default 64) cycles of request, the block treats the record as absent and moves to polling. Any late data is never used.
- R6: The block accepts clear-to-send only after `cts_n_i` has been low for CTS_HOLD (default 8) consecutive synchronized cycles. A low pulse that is shorter than this has no effect.
- R7: While `cts_n_i` stays high and no other source decides, the block keeps polling with no time limit, and `done_o` stays 0.
- R8: A clear-to-send acceptance selects four-wire UART (3'b010).
- R9: Once `done_o` is 1, `sel_o` is exactly one-hot. Both outputs stay unchanged until reset, whatever the inputs do.
- R10: `cfg_req_o` is 1 only while the block is waiting for the stored record. It falls once ready is seen, once the timeout expires, and once detection is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_n_i | input | 1 | Asynchronous strap pin; low forces serial peripheral interface |
| cts_n_i | input | 1 | Asynchronous UART clear-to-send, active low |
| cfg_req_o | output | 1 | Request for the stored configuration record |
| cfg_rdy_i | input | 1 | Record response is valid this cycle |
| cfg_valid_i | input | 1 | Stored record is valid |
| cfg_entry_i | input | 1 | Record contains a transport entry |
| cfg_xport_i | input | 2 | Transport code (00 four-wire UART, 01 two-wire UART, 10 SPI, 11 unusable) |
| sel_o | output | 3 | One-hot transport select: bit0 SPI, bit1 four-wire UART, bit2 two-wire UART |
| done_o | output | 1 | Detection complete; select is latched |

## Verification
The bench drives a table of input patterns through the main function. One pattern sets the strap low while the stored record is valid, which shows that the strap wins. Three patterns deliver each legal code, which tells apart all three decodings. Three patterns make the record unusable in different ways: valid cleared, entry cleared, or the reserved code. Each of these must fall through to clear-to-send. One pattern delivers ready only after the timeout, which separates a late response from an on-time one. Directed runs add four further cases. A clear-to-send pulse one cycle short of the hold count separates the debounce threshold from a plain level check. A long idle run separates unbounded polling from a hidden limit. Input changes after completion separate a latched result from a live decode. The last run watches the request line during a timeout.

// File: rtl/hostsel_pkg.sv
package hostsel_pkg;

  typedef enum logic [2:0] {
    ST_SETTLE = 3'd0,
    ST_STRAP  = 3'd1,
    ST_CFG    = 3'd2,
    ST_POLL   = 3'd3,
    ST_DONE   = 3'd4
  } det_state_t;

  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_NONE = 3'b000;
  localparam logic [SEL_W-1:0] SEL_SPI  = 3'b001;
  localparam logic [SEL_W-1:0] SEL_U4W  = 3'b010;
  localparam logic [SEL_W-1:0] SEL_U2W  = 3'b100;

  // Stored transport code to one-hot select; reserved code gives zero.
  function automatic logic [SEL_W-1:0] code_to_sel(input logic [1:0] code);
    case (code)
      2'b00:   return SEL_U4W;
      2'b01:   return SEL_U2W;
      2'b10:   return SEL_SPI;
      default: return SEL_NONE;
    endcase
  endfunction

  // A record decides the transport only if valid, present and legal.
  function automatic logic record_usable(input logic valid,
                                         input logic present,
                                         input logic [1:0] code);
    return valid && present && (code_to_sel(code) != SEL_NONE);
  endfunction

endpackage

// File: rtl/hostsel_sync.sv
module hostsel_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= (chain << 1) | STAGES'(d_i[b]);
    end
    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/hostsel_cts_qual.sv
module hostsel_cts_qual #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cts_n_s_i,
  output logic accept_o
);

  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

  logic [CW-1:0] streak_q;
  logic          low_seen;

  assign low_seen = en_i && !cts_n_s_i;
  assign accept_o = low_seen && (streak_q == CW'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       streak_q <= '0;
    else if (!low_seen)               streak_q <= '0;
    else if (streak_q != CW'(HOLD - 1)) streak_q <= streak_q + 1'b1;
  end

  if (HOLD > 1) begin : g_streak_chk
    // R6: acceptance needs the previous cycle low as well
    a_r6_streak: assert property (@(posedge clk) disable iff (!rst_n)
      accept_o |-> $past(low_seen));
  end

endmodule

// File: rtl/hostsel_cfg_wait.sv
module hostsel_cfg_wait #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rdy_i,
  output logic req_o,
  output logic timeout_o
);

  localparam int TW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT + 1);

  logic [TW-1:0] wait_q;

  assign req_o     = en_i;
  assign timeout_o = en_i && !rdy_i && (wait_q == TW'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wait_q <= '0;
    else if (!en_i)  wait_q <= '0;
    else if (!timeout_o) wait_q <= wait_q + 1'b1;
  end

endmodule

// File: rtl/hostsel_top.sv
module hostsel_top
  import hostsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CTS_HOLD    = 8,
  parameter int CFG_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_n_i,
  input  logic       cts_n_i,
  output logic       cfg_req_o,
  input  logic       cfg_rdy_i,
  input  logic       cfg_valid_i,
  input  logic       cfg_entry_i,
  input  logic [1:0] cfg_xport_i,
  output logic [2:0] sel_o,
  output logic       done_o
);

  localparam int SW = (SYNC_STAGES < 2) ? 1 : $clog2(SYNC_STAGES + 1);

  det_state_t       state_q, state_d;
  logic [SW-1:0]    settle_q;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             done_q;
  logic             strap_s, cts_s;
  logic             cfg_timeout_ev, cts_accept_ev, strap_spi_ev, cfg_hit_ev;

  hostsel_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({cts_n_i, strap_n_i}),
    .q_o  ({cts_s, strap_s})
  );

  hostsel_cfg_wait #(.TIMEOUT(CFG_TIMEOUT)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (state_q == ST_CFG),
    .rdy_i    (cfg_rdy_i),
    .req_o    (cfg_req_o),
    .timeout_o(cfg_timeout_ev)
  );

  hostsel_cts_qual #(.HOLD(CTS_HOLD)) u_cts (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (state_q == ST_POLL),
    .cts_n_s_i(cts_s),
    .accept_o (cts_accept_ev)
  );

  assign strap_spi_ev = (state_q == ST_STRAP) && !strap_s;
  assign cfg_hit_ev   = (state_q == ST_CFG) && cfg_rdy_i &&
                        record_usable(cfg_valid_i, cfg_entry_i, cfg_xport_i);

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    case (state_q)
      ST_SETTLE: if (settle_q == SW'(SYNC_STAGES - 1)) state_d = ST_STRAP;
      ST_STRAP: begin
        if (strap_spi_ev) begin
          state_d = ST_DONE;
          sel_d   = SEL_SPI;
        end else begin
          state_d = ST_CFG;
        end
      end
      ST_CFG: begin
        if (cfg_hit_ev) begin
          state_d = ST_DONE;
          sel_d   = code_to_sel(cfg_xport_i);
        end else if (cfg_rdy_i || cfg_timeout_ev) begin
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (cts_accept_ev) begin
          state_d = ST_DONE;
          sel_d   = SEL_U4W;
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_SETTLE;
      settle_q <= '0;
      sel_q    <= SEL_NONE;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      sel_q    <= sel_d;
      done_q   <= (state_d == ST_DONE);
      if (state_q == ST_SETTLE) settle_q <= settle_q + 1'b1;
    end
  end

  assign sel_o  = sel_q;
  assign done_o = done_q;

  // R1: nothing selected before completion
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (sel_o == SEL_NONE));
  // R9: one-hot after completion
  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones(sel_o) == 1));
  // R9: latched until reset
  a_r9_latched: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(sel_o)));
  // R2: strap low goes straight to SPI
  a_r2_strap_spi: assert property (@(posedge clk) disable iff (!rst_n)
    strap_spi_ev |=> (done_o && sel_o == SEL_SPI));
  // R5: timeout leads to polling, not to a decision
  a_r5_timeout_poll: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_timeout_ev |=> (state_q == ST_POLL && !done_o));
  // R8: accepted clear-to-send gives four-wire UART
  a_r8_cts_uart: assert property (@(posedge clk) disable iff (!rst_n)
    cts_accept_ev |=> (done_o && sel_o == SEL_U4W));
  // R10: no request once done
  a_r10_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req_o |-> !done_o);

endmodule

// File: tb/hostsel_top_tb_top.sv
module hostsel_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 8;
  localparam int TMO        = 64;
  localparam int NEVER      = 255;

  typedef struct packed {
    logic       strap;
    logic       valid;
    logic       entry;
    logic [1:0] code;
    logic [7:0] delay;
    logic       cts;
    logic [2:0] exp_sel;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 2'b01, 8'd2,   1'b0, 3'b001}, // R2 strap wins
    '{1'b1, 1'b1, 1'b1, 2'b00, 8'd3,   1'b1, 3'b010}, // R3 code 00
    '{1'b1, 1'b1, 1'b1, 2'b01, 8'd5,   1'b1, 3'b100}, // R3 code 01
    '{1'b1, 1'b1, 1'b1, 2'b10, 8'd0,   1'b0, 3'b001}, // R3 code 10
    '{1'b1, 1'b1, 1'b1, 2'b11, 8'd1,   1'b0, 3'b010}, // R4 reserved
    '{1'b1, 1'b0, 1'b1, 2'b01, 8'd1,   1'b0, 3'b010}, // R4 invalid
    '{1'b1, 1'b1, 1'b0, 2'b01, 8'd1,   1'b0, 3'b010}, // R4 no entry
    '{1'b1, 1'b1, 1'b1, 2'b01, 8'd100, 1'b0, 3'b010}, // R5 late ready
    '{1'b0, 1'b0, 1'b0, 2'b00, 8'd0,   1'b1, 3'b001}  // R2 no cts
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_n_i = 1'b1;
  logic       cts_n_i = 1'b1;
  logic       cfg_req_o;
  logic       cfg_rdy_i = 1'b0;
  logic       cfg_valid_i = 1'b0;
  logic       cfg_entry_i = 1'b0;
  logic [1:0] cfg_xport_i = 2'b00;
  logic [2:0] sel_o;
  logic       done_o;

  int   checks = 0;
  int   errors = 0;
  int   rsp_delay = 0;
  int   rsp_cnt = 0;
  logic rsp_given = 1'b0;
  logic req_seen = 1'b0;
  int   cycles = 0;

  hostsel_top dut_i (
    .clk(clk), .rst_n(rst_n), .strap_n_i(strap_n_i), .cts_n_i(cts_n_i),
    .cfg_req_o(cfg_req_o), .cfg_rdy_i(cfg_rdy_i), .cfg_valid_i(cfg_valid_i),
    .cfg_entry_i(cfg_entry_i), .cfg_xport_i(cfg_xport_i),
    .sel_o(sel_o), .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Record responder, acting between clock edges
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_cnt = 0; rsp_given = 1'b0; cfg_rdy_i = 1'b0; req_seen = 1'b0;
    end else if (cfg_req_o && !rsp_given) begin
      req_seen = 1'b1;
      if (rsp_delay != NEVER && rsp_cnt == rsp_delay) begin
        cfg_rdy_i = 1'b1; rsp_given = 1'b1;
      end else begin
        rsp_cnt++;
      end
    end else begin
      cfg_rdy_i = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 sel in reset", 32'(sel_o), 32'h0);
    check("R1 done in reset", 32'(done_o), 32'h0);
    check("R10 req in reset", 32'(cfg_req_o), 32'h0);

    // Table of patterns
    for (int v = 0; v < NV; v++) begin
      strap_n_i   = VECS[v].strap;
      cfg_valid_i = VECS[v].valid;
      cfg_entry_i = VECS[v].entry;
      cfg_xport_i = VECS[v].code;
      rsp_delay   = int'(VECS[v].delay);
      cts_n_i     = VECS[v].cts;
      do_reset();
      wait_done(400);
      check($sformatf("R3/R4/R5 vec %0d done", v), 32'(done_o), 32'h1);
      check($sformatf("R2/R3/R8 vec %0d sel", v), 32'(sel_o), 32'(VECS[v].exp_sel));
      if (!VECS[v].strap)
        check($sformatf("R2 vec %0d no request", v), 32'(req_seen), 32'h0);
    end

    // R6: short clear-to-send pulse is ignored
    strap_n_i = 1'b1; cfg_valid_i = 1'b0; rsp_delay = 0; cts_n_i = 1'b1;
    do_reset();
    repeat (20) @(negedge clk);
    cts_n_i = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    cts_n_i = 1'b1;
    repeat (20) @(negedge clk);
    check("R6 short pulse done", 32'(done_o), 32'h0);
    check("R6 short pulse sel", 32'(sel_o), 32'h0);
    cts_n_i = 1'b0;
    repeat (HOLD + 6) @(negedge clk);
    check("R8 held cts done", 32'(done_o), 32'h1);
    check("R8 held cts sel", 32'(sel_o), 32'h2);

    // R9: result latched while inputs change
    strap_n_i = 1'b0; cts_n_i = 1'b1; cfg_valid_i = 1'b1; cfg_entry_i = 1'b1;
    repeat (50) @(negedge clk);
    check("R9 latched sel", 32'(sel_o), 32'h2);
    check("R9 latched done", 32'(done_o), 32'h1);
    check("R10 req after done", 32'(cfg_req_o), 32'h0);

    // R7/R10: no host, long wait; request visible then dropped on timeout
    strap_n_i = 1'b1; cts_n_i = 1'b1; cfg_valid_i = 1'b1; cfg_entry_i = 1'b1;
    cfg_xport_i = 2'b01; rsp_delay = NEVER;
    do_reset();
    repeat (8) @(negedge clk);
    check("R10 req while waiting", 32'(cfg_req_o), 32'h1);
    repeat (TMO + 10) @(negedge clk);
    check("R10 req after timeout", 32'(cfg_req_o), 32'h0);
    check("R5 timeout no decision", 32'(done_o), 32'h0);
    repeat (3000) @(negedge clk);
    check("R7 still polling done", 32'(done_o), 32'h0);
    check("R7 still polling sel", 32'(sel_o), 32'h0);
    cts_n_i = 1'b0;
    wait_done(100);
    check("R7 late host accepted", 32'(sel_o), 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule